// File: doc/BRIEF.md
# Send Descriptor Ring Encoder

This block turns packet send requests into 128-bit transmit descriptors and writes them into a circular ring held in local memory. A request consists of one header segment, whose dword length and address come with the request, followed by zero or more payload segments. The payload segments arrive one per `segValid` cycle and each carries a byte length and an address. For every segment the block builds one descriptor. It places the segment's address, dword count and buffer offset in fixed fields, together with a 2-bit generation tag. The generation tag advances each time the write index wraps around the ring.

Before it accepts a request, the block checks the number of free slots. It keeps two 16-bit running counts, one of descriptors it has written and one of descriptors the consumer has retired. A request that needs more slots than are free is turned away with a one-cycle busy pulse and leaves the ring untouched. Once the final descriptor of a packet is in the ring, the block publishes the new tail index and the slot where the packet started.

Top module: `sendDescEncoder`

## Requirements
- R1: After reset, `ringWe`, `tailStrobe` and `reqBusy` are low and `reqReady` is high. The first accepted descriptor is written to slot 0 with generation 0.
- R2: A request is accepted only while `reqReady` is high. Its header descriptor is written in the cycle after acceptance. This descriptor has the first flag (word 0 bit 12) set, buffer offset 0 (word 0 bits 10:0) and dword count `reqHdrDwords` (word 0 bits 26:16).
- R3: The address ports carry byte-address bits 47:2. Address bits 31:2 go to word 0 bits 63:34 and address bits 47:32 go to word 1 bits 15:0. Word 0 bits 33:32 and 29:27 and word 1 bits 63:16 are zero. `ringData[63:0]` is word 0 and `ringData[127:64]` is word 1.
- R4: A payload descriptor's dword count is its byte length rounded up to a whole dword, up to a maximum of 2047. Its offset is the sum, modulo 2048, of the dword counts of all earlier descriptors of the same packet, including the header.
- R5: The large-buffer flag (word 0 bit 14) is set on every descriptor of a packet exactly when `reqLargeBuf` was high at acceptance.
- R6: The last flag (bit 11) appears only on the final descriptor of a packet. The head-to-host flag (bit 13) and the interrupt flag (bit 15) also appear only there, and only if they were requested. With `reqSegs` = 0 the header is the final descriptor.
- R7: Descriptors go to consecutive slots, and after slot RING_DEPTH-1 the next slot is 0. The generation field (word 0 bits 31:30) increments modulo 4 for descriptors written after each wrap.
- R8: The number of free slots is RING_DEPTH-1 minus the descriptors outstanding. A request that needs 1+`reqSegs` slots, more than are free, raises `reqBusy` for one cycle in the next cycle. Nothing is written and the tail does not move. A request that needs exactly the free count is accepted.
- R9: One cycle after the final descriptor of a packet is written, `tailStrobe` pulses. At the same time `tailIdx` shows the slot after that descriptor and `pktStartIdx` shows the header's slot.
- R10: A `retireValid` cycle releases `retireNum` slots, and requests refused before the release then fit.
- R11: Each payload descriptor is written in the cycle after its `segValid` cycle. Cycles without `segValid` write nothing, and `segValid` while `reqReady` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | New send request |
| reqHdrAddr | input | 46 | Header address bits 47:2 |
| reqHdrDwords | input | 11 | Header length in dwords |
| reqSegs | input | SEG_W | Number of payload segments |
| reqLargeBuf | input | 1 | Use large buffer on all descriptors |
| reqHeadToHost | input | 1 | Request head write-back on final descriptor |
| reqIntr | input | 1 | Request interrupt on final descriptor |
| reqReady | output | 1 | Block can take a new request |
| reqBusy | output | 1 | Previous-cycle request refused for lack of space |
| segValid | input | 1 | Payload segment present |
| segAddr | input | 46 | Payload address bits 47:2 |
| segBytes | input | 13 | Payload length in bytes |
| retireValid | input | 1 | Consumer retires descriptors |
| retireNum | input | IDX_W+1 | Descriptors retired |
| ringWe | output | 1 | Ring write enable |
| ringAddr | output | IDX_W | Ring slot written |
| ringData | output | 128 | Descriptor, word 1 above word 0 |
| tailStrobe | output | 1 | New tail published |
| tailIdx | output | IDX_W | Published tail slot |
| pktStartIdx | output | IDX_W | Header slot of the published packet |

## Verification
The bench uses an 8-slot ring, so the wrap and all four generation values come up within a few dozen packets. The sweep crosses payload counts from zero to three with every combination of the three option flags. With zero payload segments, the flags on the header are the only thing that separates it from a multi-descriptor packet. The mix of option flags shows whether large-buffer is copied onto every descriptor while the other two stay on the final one only. Odd byte lengths, exact multiples and the 8188-byte maximum separate the rounding from plain truncation. Gap cycles between segments show whether the block writes only on `segValid`. A fill sequence then checks refusal one slot over the limit, acceptance exactly at the limit, and release by retirement.

// File: rtl/sdePkg.sv
package sdePkg;

  localparam int ADDR_DW_W = 46;
  localparam int DW_CNT_W  = 11;

  typedef struct packed {
    logic hdrWr;
    logic hdrLast;
    logic segWr;
    logic segLast;
    logic refuse;
  } sdeStrobes_t;

  function automatic logic [127:0] makeDesc(
    input logic [ADDR_DW_W-1:0] dwAddr,
    input logic [DW_CNT_W-1:0]  dwCount,
    input logic [DW_CNT_W-1:0]  dwOffset,
    input logic [1:0]           genTag,
    input logic                 isFirst,
    input logic                 isLast,
    input logic                 headToHost,
    input logic                 largeBuf,
    input logic                 intrReq
  );
    logic [63:0] wordLo;
    logic [63:0] wordHi;
    wordLo = {dwAddr[29:0], 2'b00, genTag, 3'b000, dwCount,
              intrReq, largeBuf, headToHost, isFirst, isLast, dwOffset};
    wordHi = {48'd0, dwAddr[45:30]};
    return {wordHi, wordLo};
  endfunction

endpackage

// File: rtl/sdeCtrl.sv
module sdeCtrl
  import sdePkg::*;
#(
  parameter int SEG_W = 4,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [SEG_W-1:0]  reqSegs,
  input  logic              segValid,
  input  logic [CNT_W-1:0]  freeCount,
  output sdeStrobes_t       st,
  output logic              reqReady
);

  typedef enum logic {S_IDLE, S_PAYLOAD} ctrlState_t;

  ctrlState_t       state;
  logic [SEG_W-1:0] remaining;
  logic [CNT_W-1:0] needSlots;
  logic             fits;

  always_comb begin
    needSlots  = CNT_W'(reqSegs) + CNT_W'(1);
    fits       = needSlots <= freeCount;
    reqReady   = (state == S_IDLE);
    st.hdrWr   = reqReady & reqValid & fits;
    st.hdrLast = st.hdrWr & (reqSegs == '0);
    st.refuse  = reqReady & reqValid & ~fits;
    st.segWr   = ~reqReady & segValid;
    st.segLast = st.segWr & (remaining == SEG_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      remaining <= '0;
    end else begin
      if (st.hdrWr) begin
        remaining <= reqSegs;
        if (reqSegs != '0) state <= S_PAYLOAD;
      end else if (st.segWr) begin
        remaining <= remaining - SEG_W'(1);
        if (st.segLast) state <= S_IDLE;
      end
    end
  end

  // R11: while payload is pending at least one segment is still owed
  a_r11_pending_count: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PAYLOAD) |-> (remaining != '0));

endmodule

// File: rtl/sdeDatapath.sv
module sdeDatapath
  import sdePkg::*;
#(
  parameter int RING_DEPTH = 256,
  parameter int IDX_W      = $clog2(RING_DEPTH),
  parameter int CNT_W      = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  sdeStrobes_t          st,
  input  logic [ADDR_DW_W-1:0] reqHdrAddr,
  input  logic [DW_CNT_W-1:0]  reqHdrDwords,
  input  logic                 reqLargeBuf,
  input  logic                 reqHeadToHost,
  input  logic                 reqIntr,
  input  logic [ADDR_DW_W-1:0] segAddr,
  input  logic [12:0]          segBytes,
  input  logic                 retireValid,
  input  logic [IDX_W:0]       retireNum,
  output logic                 ringWe,
  output logic [IDX_W-1:0]     ringAddr,
  output logic [127:0]         ringData,
  output logic                 tailStrobe,
  output logic [IDX_W-1:0]     tailIdx,
  output logic [IDX_W-1:0]     pktStartIdx,
  output logic                 reqBusy,
  output logic [CNT_W-1:0]     freeCount
);

  localparam logic [CNT_W-1:0] RING_CAP = CNT_W'(RING_DEPTH - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RING_DEPTH - 1);

  logic [IDX_W-1:0]    tail, startReg, tailNext;
  logic [1:0]          gen;
  logic [DW_CNT_W-1:0] offReg, segDw;
  logic                lbReg, hthReg, intrReg;
  logic [CNT_W-1:0]    added, removed;
  logic                wrAny, wrapNow;
  logic [127:0]        descNext;

  always_comb begin
    wrAny     = st.hdrWr | st.segWr;
    wrapNow   = (tail == LAST_IDX);
    tailNext  = wrapNow ? '0 : tail + IDX_W'(1);
    segDw     = segBytes[12:2] + DW_CNT_W'(|segBytes[1:0]);
    freeCount = RING_CAP - (added - removed);
    if (st.hdrWr)
      descNext = makeDesc(reqHdrAddr, reqHdrDwords, '0, gen, 1'b1, st.hdrLast,
                          reqHeadToHost & st.hdrLast, reqLargeBuf,
                          reqIntr & st.hdrLast);
    else
      descNext = makeDesc(segAddr, segDw, offReg, gen, 1'b0, st.segLast,
                          hthReg & st.segLast, lbReg, intrReg & st.segLast);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tail        <= '0;
      gen         <= '0;
      startReg    <= '0;
      offReg      <= '0;
      lbReg       <= 1'b0;
      hthReg      <= 1'b0;
      intrReg     <= 1'b0;
      added       <= '0;
      removed     <= '0;
      ringWe      <= 1'b0;
      ringAddr    <= '0;
      ringData    <= '0;
      tailStrobe  <= 1'b0;
      tailIdx     <= '0;
      pktStartIdx <= '0;
      reqBusy     <= 1'b0;
    end else begin
      ringWe     <= wrAny;
      reqBusy    <= st.refuse;
      tailStrobe <= ringWe & ringData[11];
      if (ringWe & ringData[11]) begin
        tailIdx     <= tail;
        pktStartIdx <= startReg;
      end
      if (wrAny) begin
        ringAddr <= tail;
        ringData <= descNext;
        tail     <= tailNext;
        if (wrapNow) gen <= gen + 2'd1;
        added    <= added + CNT_W'(1);
      end
      if (st.hdrWr) begin
        startReg <= tail;
        offReg   <= reqHdrDwords;
        lbReg    <= reqLargeBuf;
        hthReg   <= reqHeadToHost;
        intrReg  <= reqIntr;
      end else if (st.segWr) begin
        offReg <= offReg + segDw;
      end
      if (retireValid) removed <= removed + CNT_W'(retireNum);
    end
  end

  // R7: a write from the top slot lands the tail at 0 and bumps the generation
  a_r7_wrap_gen: assert property (@(posedge clk) disable iff (!rstN)
    (wrAny && wrapNow) |=> (tail == '0 && gen == $past(gen) + 2'd1));

  // R8: outstanding descriptors never exceed the usable ring capacity
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (added - removed) <= RING_CAP);

endmodule

// File: rtl/sendDescEncoder.sv
module sendDescEncoder
  import sdePkg::*;
#(
  parameter int RING_DEPTH = 256,
  parameter int SEG_W      = 4,
  parameter int IDX_W      = $clog2(RING_DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [45:0]      reqHdrAddr,
  input  logic [10:0]      reqHdrDwords,
  input  logic [SEG_W-1:0] reqSegs,
  input  logic             reqLargeBuf,
  input  logic             reqHeadToHost,
  input  logic             reqIntr,
  output logic             reqReady,
  output logic             reqBusy,
  input  logic             segValid,
  input  logic [45:0]      segAddr,
  input  logic [12:0]      segBytes,
  input  logic             retireValid,
  input  logic [IDX_W:0]   retireNum,
  output logic             ringWe,
  output logic [IDX_W-1:0] ringAddr,
  output logic [127:0]     ringData,
  output logic             tailStrobe,
  output logic [IDX_W-1:0] tailIdx,
  output logic [IDX_W-1:0] pktStartIdx
);

  localparam int CNT_W = 16;

  sdeStrobes_t      st;
  logic [CNT_W-1:0] freeCount;

  sdeCtrl #(.SEG_W(SEG_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSegs(reqSegs),
    .segValid(segValid), .freeCount(freeCount), .st(st), .reqReady(reqReady)
  );

  sdeDatapath #(.RING_DEPTH(RING_DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .st(st),
    .reqHdrAddr(reqHdrAddr), .reqHdrDwords(reqHdrDwords),
    .reqLargeBuf(reqLargeBuf), .reqHeadToHost(reqHeadToHost), .reqIntr(reqIntr),
    .segAddr(segAddr), .segBytes(segBytes),
    .retireValid(retireValid), .retireNum(retireNum),
    .ringWe(ringWe), .ringAddr(ringAddr), .ringData(ringData),
    .tailStrobe(tailStrobe), .tailIdx(tailIdx), .pktStartIdx(pktStartIdx),
    .reqBusy(reqBusy), .freeCount(freeCount)
  );

  // R8: a refusal is never accompanied by a ring write
  a_r8_busy_no_write: assert property (@(posedge clk) disable iff (!rstN)
    reqBusy |-> !ringWe);

  // R2: a descriptor flagged first always carries offset zero
  a_r2_first_offset: assert property (@(posedge clk) disable iff (!rstN)
    (ringWe && ringData[12]) |-> (ringData[10:0] == '0));

  // R9: tail publication follows a final-descriptor write by one cycle
  a_r9_tail_after_last: assert property (@(posedge clk) disable iff (!rstN)
    tailStrobe |-> $past(ringWe && ringData[11]));

endmodule

// File: tb/sim_sendDescEncoder.sv
module sim_sendDescEncoder;

  localparam int DEPTH = 8;
  localparam int SEGW  = 4;
  localparam int IDXW  = 3;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             reqValid = 1'b0;
  logic [45:0]      reqHdrAddr = '0;
  logic [10:0]      reqHdrDwords = '0;
  logic [SEGW-1:0]  reqSegs = '0;
  logic             reqLargeBuf = 1'b0, reqHeadToHost = 1'b0, reqIntr = 1'b0;
  logic             reqReady, reqBusy;
  logic             segValid = 1'b0;
  logic [45:0]      segAddr = '0;
  logic [12:0]      segBytes = '0;
  logic             retireValid = 1'b0;
  logic [IDXW:0]    retireNum = '0;
  logic             ringWe, tailStrobe;
  logic [IDXW-1:0]  ringAddr, tailIdx, pktStartIdx;
  logic [127:0]     ringData;

  int nChecks = 0, nErrors = 0;
  int expTail = 0, expGen = 0, outstanding = 0;
  bit done = 0;

  sendDescEncoder #(.RING_DEPTH(DEPTH), .SEG_W(SEGW)) u0 (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] expDesc(input logic [45:0] a, input int cnt,
      input int off, input int g, input bit f, input bit l, input bit h,
      input bit lb, input bit irq);
    logic [127:0] d = '0;
    d[63:34] = a[29:0];
    d[31:30] = g[1:0];
    d[26:16] = cnt[10:0];
    d[15] = irq; d[14] = lb; d[13] = h; d[12] = f; d[11] = l;
    d[10:0] = off[10:0];
    d[79:64] = a[45:30];
    return d;
  endfunction

  function automatic logic [45:0] hdrAddrF(input int p);
    return 46'(64'h0123_4567_89AB + 64'(p) * 64'h1_0000_0011);
  endfunction
  function automatic int hdrDwF(input int p);
    return (p * 5) % 16 + 1;
  endfunction
  function automatic logic [45:0] segAddrF(input int p, input int k);
    return 46'(64'h2A_F000_0000 + 64'(p * 64 + k) * 64'h4_0000_0101);
  endfunction
  function automatic int segBytesF(input int p, input int k);
    if (k == 0 && p % 8 == 7) return 8188;
    return (p * 7 + k * 13) % 40 + 1;
  endfunction

  function automatic void advance();
    expTail++;
    if (expTail == DEPTH) begin
      expTail = 0;
      expGen = (expGen + 1) % 4;
    end
  endfunction

  task automatic retire(input int n);
    retireValid = 1'b1;
    retireNum = (IDXW+1)'(n);
    @(negedge clk);
    retireValid = 1'b0;
    outstanding -= n;
  endtask

  task automatic sendPkt(input int p, input int nseg, input bit lb, input bit hth,
                         input bit irq, input bit gap, output bit accepted);
    bit expBusy;
    int off, startIdx, dw;
    expBusy = (nseg + 1) > (DEPTH - 1 - outstanding);
    chk(reqReady === 1'b1, "R11 ready before request", 128'(reqReady), 128'(1));
    reqValid = 1'b1; reqHdrAddr = hdrAddrF(p); reqHdrDwords = 11'(hdrDwF(p));
    reqSegs = SEGW'(nseg); reqLargeBuf = lb; reqHeadToHost = hth; reqIntr = irq;
    @(negedge clk);
    reqValid = 1'b0;
    if (expBusy) begin
      chk(reqBusy === 1'b1, "R8 busy on shortage", 128'(reqBusy), 128'(1));
      chk(ringWe === 1'b0, "R8 no write when refused", 128'(ringWe), 128'(0));
      accepted = 0;
      return;
    end
    accepted = 1;
    chk(reqBusy === 1'b0, "R8 no busy when space", 128'(reqBusy), 128'(0));
    startIdx = expTail;
    chk(ringWe === 1'b1 && ringAddr === IDXW'(expTail), "R1 R7 header slot",
        128'({ringWe, ringAddr}), 128'({1'b1, IDXW'(expTail)}));
    chk(ringData === expDesc(hdrAddrF(p), hdrDwF(p), 0, expGen, 1, nseg == 0,
                             hth && nseg == 0, lb, irq && nseg == 0),
        "R2 R3 R5 R6 header descriptor", ringData,
        expDesc(hdrAddrF(p), hdrDwF(p), 0, expGen, 1, nseg == 0,
                hth && nseg == 0, lb, irq && nseg == 0));
    advance();
    off = hdrDwF(p);
    for (int k = 0; k < nseg; k++) begin
      if (gap && k > 0) begin
        @(negedge clk);
        chk(ringWe === 1'b0, "R11 no write without segValid", 128'(ringWe), 128'(0));
      end
      segValid = 1'b1; segAddr = segAddrF(p, k); segBytes = 13'(segBytesF(p, k));
      @(negedge clk);
      segValid = 1'b0;
      dw = (segBytesF(p, k) + 3) / 4;
      chk(ringWe === 1'b1 && ringAddr === IDXW'(expTail), "R7 R11 payload slot",
          128'({ringWe, ringAddr}), 128'({1'b1, IDXW'(expTail)}));
      chk(ringData === expDesc(segAddrF(p, k), dw, off % 2048, expGen, 0,
                               k == nseg - 1, hth && k == nseg - 1, lb,
                               irq && k == nseg - 1),
          "R3 R4 R5 R6 R7 payload descriptor", ringData,
          expDesc(segAddrF(p, k), dw, off % 2048, expGen, 0, k == nseg - 1,
                  hth && k == nseg - 1, lb, irq && k == nseg - 1));
      advance();
      off += dw;
    end
    @(negedge clk);
    chk(tailStrobe === 1'b1 && tailIdx === IDXW'(expTail) &&
        pktStartIdx === IDXW'(startIdx), "R9 tail publication",
        128'({tailStrobe, tailIdx, pktStartIdx}),
        128'({1'b1, IDXW'(expTail), IDXW'(startIdx)}));
    outstanding += nseg + 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    bit acc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(ringWe === 1'b0 && tailStrobe === 1'b0 && reqBusy === 1'b0 &&
        reqReady === 1'b1, "R1 reset state",
        128'({ringWe, tailStrobe, reqBusy, reqReady}), 128'(4'b0001));

    // segValid while idle must be ignored
    segValid = 1'b1; segAddr = segAddrF(0, 0); segBytes = 13'd8;
    @(negedge clk);
    segValid = 1'b0;
    chk(ringWe === 1'b0, "R11 segValid ignored when idle", 128'(ringWe), 128'(0));

    // sweep payload counts and option flags, wrapping the ring repeatedly
    for (int p = 0; p < 32; p++) begin
      int opts;
      opts = p / 4;
      sendPkt(p, p % 4, opts[0], opts[1], opts[2], p[0], acc);
      retire(outstanding);
    end

    // fill sequence: refusal, exact fit, release
    sendPkt(40, 3, 0, 1, 0, 0, acc);
    sendPkt(41, 3, 1, 0, 1, 0, acc);
    chk(acc == 0, "R8 refused one over free count", 128'(acc), 128'(0));
    sendPkt(42, 2, 0, 0, 1, 0, acc);
    chk(acc == 1, "R8 accepted at exact free count", 128'(acc), 128'(1));
    sendPkt(43, 0, 0, 0, 0, 0, acc);
    chk(acc == 0, "R8 refused when full", 128'(acc), 128'(0));
    retire(7);
    sendPkt(44, 6, 1, 1, 1, 1, acc);
    chk(acc == 1, "R10 full-ring request fits after retire", 128'(acc), 128'(1));
    retire(outstanding);
    sendPkt(45, 0, 1, 1, 1, 0, acc);
    chk(acc == 1, "R10 accepted after drain", 128'(acc), 128'(1));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule